// File: doc/BRIEF.md
# DMA Channel Register File

This block is the processor-side register file of a four-channel DMA controller that sits on an 8-bit I/O bus. Software drives it with write and read strobes, a 4-bit port offset and a byte of data. The block keeps a 16-bit transfer address and a 16-bit transfer count for each channel. Software loads and reads these values one byte at a time through a byte pointer, and the same pointer serves every channel.

The block also holds a 6-bit mode field per channel, a 4-bit channel mask and a command byte, and it provides a master-clear operation. A separate transfer engine receives the programmed base values, the modes, the mask bits and the command byte as flat output buses. The count a channel holds is always one less than the number of transfers it will make.

Top module: `dma_regfile`

## Requirements
- R1: Reset behaviour. After reset the byte pointer selects the low byte and all four mask bits read 1. The command byte, every address and count register and every mode field read 0.
- R2: Address writes. A write to offset 2c, for channel c in 0..3, loads the byte of channel c's address that the pointer selects, bits 7:0 when the pointer is low and bits 15:8 when it is high. The byte goes into both the base copy and the current copy. A read of the same offset returns the selected byte of the current copy.
- R3: Shared byte pointer. Every read or write to an offset in 0..7 flips the one pointer after the access. A read at offset 4 that follows a single write at offset 0 therefore returns the high byte.
- R4: Clearing the pointer. Any write to offset 0xC sets the pointer to the low byte, whatever the data.
- R5: Masking one channel. A write to offset 0xA picks a channel with data bits 1:0. Data bit 2 equal to 1 sets that channel's mask bit, and 0 clears it. The other mask bits keep their values.
- R6: Mode writes. A write to offset 0xB picks a channel with data bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode. The auto-initialise bit, data bit 4, therefore lands in mode bit 2.
- R7: Count registers. Offset 2c+1 holds channel c's transfer count, which is one less than the number of transfers. Writes and reads of it follow the byte-pointer rules of R2.
- R8: Master clear. A write to offset 0xD sets the pointer to the low byte, sets all mask bits and clears the command byte.
- R9: A write to offset 0xE clears all four mask bits.
- R10: A write to offset 0xF loads the four mask bits from data bits 3:0, where bit n masks channel n.
- R11: A write to offset 0x8 stores the data byte as the command byte.
- R12: A read of an offset from 8 to 15 returns 0x00 and leaves the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one access per clock |
| rd_en | input | 1 | Read strobe, one access per clock |
| port_sel | input | 4 | Register port offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while rd_en is high |
| base_addr_o | output | 64 | Base address per channel, channel c at bits [16c+15:16c] |
| base_cnt_o | output | 64 | Base count per channel, same packing |
| mode_o | output | 24 | Mode per channel, channel c at bits [6c+5:6c] |
| mask_o | output | 4 | Mask bit per channel |
| cmd_o | output | 8 | Command byte |

## Verification
The assertions take for granted that wr_en and rd_en are never high in the same cycle and that each access lasts one clock. Inside that assumption, each port access either flips the pointer or leaves it alone, and the mask and clear outcomes follow the port offset alone. The stimulus uses one task that raises exactly one strobe for one clock and drops it just after the edge. The pointer state is observed only through ordinary reads, whose result depends on which byte comes back.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 4,
  parameter int RW  = 16,
  parameter int MW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        port_sel,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NCH*RW-1:0] base_addr_o,
  output logic [NCH*RW-1:0] base_cnt_o,
  output logic [NCH*MW-1:0] mode_o,
  output logic [NCH-1:0]    mask_o,
  output logic [7:0]        cmd_o
);
  localparam int CHW = $clog2(NCH);

  logic [RW-1:0] base_a [NCH];
  logic [RW-1:0] cur_a  [NCH];
  logic [RW-1:0] base_c [NCH];
  logic [RW-1:0] cur_c  [NCH];
  logic [MW-1:0] mode_r [NCH];
  logic [NCH-1:0] mask_r;
  logic [7:0]     cmd_r;
  logic           hi_ptr;

  wire            chan_port = !port_sel[3];
  wire [CHW-1:0]  ch        = port_sel[CHW:1];
  wire            is_cnt    = port_sel[0];
  wire            acc       = (wr_en | rd_en) & chan_port;
  wire [CHW-1:0]  dsel      = wdata[CHW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        base_a[c] <= '0;
        cur_a[c]  <= '0;
        base_c[c] <= '0;
        cur_c[c]  <= '0;
        mode_r[c] <= '0;
      end
      mask_r <= '1;
      cmd_r  <= '0;
      hi_ptr <= 1'b0;
    end else begin
      if (wr_en && chan_port) begin
        if (is_cnt) begin
          if (hi_ptr) begin
            base_c[ch][15:8] <= wdata;
            cur_c[ch][15:8]  <= wdata;
          end else begin
            base_c[ch][7:0] <= wdata;
            cur_c[ch][7:0]  <= wdata;
          end
        end else begin
          if (hi_ptr) begin
            base_a[ch][15:8] <= wdata;
            cur_a[ch][15:8]  <= wdata;
          end else begin
            base_a[ch][7:0] <= wdata;
            cur_a[ch][7:0]  <= wdata;
          end
        end
      end
      if (acc) hi_ptr <= !hi_ptr;
      if (wr_en && !chan_port) begin
        case (port_sel[2:0])
          3'd0: cmd_r <= wdata;
          3'd2: mask_r[dsel] <= wdata[2];
          3'd3: mode_r[dsel] <= wdata[7:2];
          3'd4: hi_ptr <= 1'b0;
          3'd5: begin
            hi_ptr <= 1'b0;
            mask_r <= '1;
            cmd_r  <= '0;
          end
          3'd6: mask_r <= '0;
          3'd7: mask_r <= wdata[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  logic [RW-1:0] rsel;
  always_comb begin
    rsel  = is_cnt ? cur_c[ch] : cur_a[ch];
    rdata = 8'h00;
    if (rd_en && chan_port) rdata = hi_ptr ? rsel[15:8] : rsel[7:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign base_addr_o[c*RW +: RW] = base_a[c];
    assign base_cnt_o[c*RW +: RW]  = base_c[c];
    assign mode_o[c*MW +: MW]      = mode_r[c];
  end
  assign mask_o = mask_r;
  assign cmd_o  = cmd_r;

  a_r3_ptr_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(wr_en && rd_en)) |=> (hi_ptr != $past(hi_ptr)));
  a_r12_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !chan_port) |=> $stable(hi_ptr));
  a_r4_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 4'hC) |=> !hi_ptr);
  a_r8_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 4'hD) |=> (!hi_ptr && mask_o == '1 && cmd_o == 8'h00));
  a_r9_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 4'hE) |=> (mask_o == '0));
  a_r5_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 4'hA) |=> (mask_o[$past(dsel)] == $past(wdata[2])));
  a_r12_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !chan_port) |-> (rdata == 8'h00));
endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] port_sel = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [63:0] base_addr_o, base_cnt_o;
  logic [23:0] mode_o;
  logic [3:0] mask_o;
  logic [7:0] cmd_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] got;

  always #10 clk = !clk;

  dma_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
    .wdata(wdata), .rdata(rdata), .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o),
    .mode_o(mode_o), .mask_o(mask_o), .cmd_o(cmd_o)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       rd;
    logic [3:0] off;
    logic [7:0] d;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{4'd4,  1'b0, 4'hC, 8'h00},
    '{4'd2,  1'b0, 4'h0, 8'h34},
    '{4'd2,  1'b0, 4'h0, 8'h12},
    '{4'd2,  1'b1, 4'h0, 8'h34},  // R2 low byte
    '{4'd2,  1'b1, 4'h0, 8'h12},  // R2 high byte
    '{4'd7,  1'b0, 4'h3, 8'hFF},
    '{4'd7,  1'b0, 4'h3, 8'h00},
    '{4'd7,  1'b1, 4'h3, 8'hFF},  // R7
    '{4'd4,  1'b0, 4'hC, 8'h5A},
    '{4'd4,  1'b1, 4'h3, 8'hFF},  // R4 pointer back to low
    '{4'd4,  1'b0, 4'hC, 8'h00},
    '{4'd3,  1'b0, 4'h4, 8'hAA},
    '{4'd3,  1'b1, 4'h0, 8'h12},  // R3 pointer shared: high byte of ch0
    '{4'd3,  1'b1, 4'h4, 8'hAA},  // R3 back to low
    '{4'd3,  1'b1, 4'h4, 8'h00},  // R3 high
    '{4'd12, 1'b1, 4'h9, 8'h00},  // R12 returns zero
    '{4'd12, 1'b1, 4'h0, 8'h34},  // R12 pointer unchanged
    '{4'd7,  1'b1, 4'h3, 8'h00},  // R7 high byte of count
    '{4'd2,  1'b1, 4'h6, 8'h00}   // R2 ch3 untouched
  };

  task automatic op(input bit rd, input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    wr_en = !rd; rd_en = rd; port_sel = off; wdata = d;
    #5 got = rdata;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    chk("R1", {60'd0, mask_o}, 64'hF);
    chk("R1", {56'd0, cmd_o}, 64'h0);
    chk("R1", base_addr_o | base_cnt_o, 64'h0);
    chk("R1", {40'd0, mode_o}, 64'h0);
    op(1, 4'h1, 8'h00);
    chk("R1", {56'd0, got}, 64'h0);
    op(1, 4'h1, 8'h00);
    op(0, 4'hC, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op(VT[i].rd, VT[i].off, VT[i].d);
      if (VT[i].rd) chk($sformatf("R%0d vec %0d", VT[i].req, i), {56'd0, got}, {56'd0, VT[i].d});
    end

    chk("R2", {48'd0, base_addr_o[15:0]}, 64'h1234);
    chk("R2", {48'd0, base_addr_o[47:32]}, 64'h00AA);
    chk("R7", {48'd0, base_cnt_o[31:16]}, 64'h00FF);

    op(0, 4'hE, 8'h00);
    chk("R9", {60'd0, mask_o}, 64'h0);
    op(0, 4'hA, 8'h06);
    chk("R5", {60'd0, mask_o}, 64'h4);
    op(0, 4'hA, 8'h05);
    chk("R5", {60'd0, mask_o}, 64'h6);
    op(0, 4'hA, 8'h02);
    chk("R5", {60'd0, mask_o}, 64'h2);
    op(0, 4'hF, 8'hFA);
    chk("R10", {60'd0, mask_o}, 64'hA);

    op(0, 4'hB, 8'h55);
    chk("R6", {58'd0, mode_o[11:6]}, 64'h15);
    op(0, 4'hB, 8'hC3);
    chk("R6", {58'd0, mode_o[23:18]}, 64'h30);
    chk("R6", {58'd0, mode_o[5:0]}, 64'h0);
    chk("R6 autoinit", {63'd0, mode_o[8]}, 64'h1);

    op(0, 4'h8, 8'h24);
    chk("R11", {56'd0, cmd_o}, 64'h24);

    op(0, 4'hC, 8'h00);
    op(1, 4'h0, 8'h00);
    op(0, 4'hD, 8'h00);
    chk("R8", {60'd0, mask_o}, 64'hF);
    chk("R8", {56'd0, cmd_o}, 64'h0);
    op(1, 4'h0, 8'h00);
    chk("R8", {56'd0, got}, 64'h34);
    chk("R8", {48'd0, base_addr_o[15:0]}, 64'h1234);

    finish_run();
  end
endmodule